// File: doc/BRIEF.md
# Prefetch Streaming Slave for a Multiplexed Local Bus

This block sits on the user side of a multiplexed address/data local bus. It keeps a FIFO of user words that a producer fills through a simple write port. While that FIFO holds at least one word, the block drives its active-low ready line low. This asks the bus master to run a prefetch read burst at address zero. Each read beat at that address returns the next word in FIFO order and removes it from the FIFO.

Accesses to other addresses go to a small register file. Both reads and writes are supported there, and burst accesses increment the address on each beat. A register cycle may interrupt streaming at any point. The master ends the prefetch burst early with its last-beat strobe and then serves the register access. After that access the ready line is still low whenever words remain, so prefetching resumes on its own.

Bus timing is fixed and has no wait states. The address and direction are captured on the clock edge where the address strobe is low. Each following edge completes one data beat. The beat sampled with the last-beat strobe low is the final one.

Top module: `lb_prefetch_slave`

## Requirements
- R1: After reset, readyN is high, ladOe is low, qFull is low and every register reads back as zero.
- R2: readyN is low exactly while the FIFO holds at least one word, and high when the FIFO is empty.
- R3: The address (low ADDR_W bits of ladIn) and the direction (wnR, 1 = write) are captured on the edge where adsN is low. Every later edge is one data beat, and the beat taken with blastN low ends the cycle.
- R4: A read beat at address 0 presents the oldest FIFO word on ladOut and removes exactly that one word.
- R5: A prefetch burst ended early by blastN removes only the beats it transferred. The remaining words stay in order for the next burst.
- R6: A read beat at address 0 with an empty FIFO returns zero and removes nothing.
- R7: Addresses 1 to NUM_REGS hold register file words. A value written there reads back unchanged, and a burst advances the address by one per beat.
- R8: A write to address 0, or to an address above NUM_REGS, changes no state. Reads above NUM_REGS return zero.
- R9: ladOe is high only during the data beats of a read cycle, and it is low in the cycle after the final beat.
- R10: qFull is high when DEPTH words are held. A push while full is dropped.
- R11: readyN stays low across a register cycle that interrupts streaming while words remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adsN | input | 1 | Address strobe, active low |
| wnR | input | 1 | Direction at address phase, 1 = write |
| blastN | input | 1 | Last-beat strobe, active low |
| ladIn | input | DATA_W | Multiplexed address/data from master |
| ladOut | output | DATA_W | Read data towards master |
| ladOe | output | 1 | Drive enable for ladOut |
| readyN | output | 1 | Prefetch request, active low |
| qWrEn | input | 1 | FIFO push strobe |
| qWrData | input | DATA_W | FIFO push word |
| qFull | output | 1 | FIFO full |

## Verification
The bench builds the block with DEPTH = 4 and NUM_REGS = 4. The shallow FIFO lets the bench fill it, overflow it and drain it fully within a few bus cycles. With four registers, address 5 is the first address outside the register file, so the out-of-range write and read path is exercised next to the valid addresses. Data widths stay at 16 bits, which keeps the address and data fields the same size on the multiplexed bus.

// File: rtl/lbps_pkg.sv
package lbps_pkg;
  typedef struct packed {
    logic latch;
    logic beat;
    logic popQ;
    logic regWr;
    logic incAddr;
    logic driveBus;
  } lbStrobes_t;
endpackage

// File: rtl/lbps_ctrl.sv
module lbps_ctrl
  import lbps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       adsN,
  input  logic       wnR,
  input  logic       blastN,
  input  logic       isPrefetch,
  input  logic       qEmpty,
  output lbStrobes_t strobes,
  output logic       ladOe
);
  typedef enum logic {S_IDLE, S_DATA} busState_t;

  busState_t state;
  logic      dirWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      dirWrite <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (!adsN) begin
          state    <= S_DATA;
          dirWrite <= wnR;
        end
        S_DATA: if (!blastN) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.latch    = (state == S_IDLE) && !adsN;
    strobes.beat     = (state == S_DATA);
    strobes.popQ     = strobes.beat && !dirWrite && isPrefetch && !qEmpty;
    strobes.regWr    = strobes.beat && dirWrite && !isPrefetch;
    strobes.incAddr  = strobes.beat && !isPrefetch;
    strobes.driveBus = strobes.beat && !dirWrite;
  end

  assign ladOe = strobes.driveBus;

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && !blastN) |=> !ladOe); // R9
endmodule

// File: rtl/lbps_datapath.sv
module lbps_datapath
  import lbps_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lbStrobes_t        strobes,
  input  logic [DATA_W-1:0] ladIn,
  input  logic              qWrEn,
  input  logic [DATA_W-1:0] qWrData,
  output logic [DATA_W-1:0] ladOut,
  output logic              isPrefetch,
  output logic              qEmpty,
  output logic              qFull,
  output logic              readyN
);
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] regOffset;
  logic [REG_IDX_W-1:0] regIdx;
  logic              regHit;
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] regRead;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop;

  // address capture and per-beat advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                addrReg <= '0;
    else if (strobes.latch)   addrReg <= ladIn[ADDR_W-1:0];
    else if (strobes.incAddr) addrReg <= addrReg + 1'b1;
  end

  assign isPrefetch = (addrReg == '0);
  assign regOffset  = addrReg - 1'b1;
  assign regIdx     = regOffset[REG_IDX_W-1:0];
  assign regHit     = !isPrefetch && (addrReg <= ADDR_W'(NUM_REGS));

  // register file, one slot per generate pass
  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (strobes.regWr && regHit && regIdx == REG_IDX_W'(g))
        regFile[g] <= ladIn;
    end
  end

  always_comb begin
    regRead = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (regHit && regIdx == REG_IDX_W'(i)) regRead = regFile[i];
  end

  // user data FIFO
  assign qEmpty = (count == '0);
  assign qFull  = (count == CNT_W'(DEPTH));
  assign doPush = qWrEn && !qFull;
  assign doPop  = strobes.popQ && !qEmpty;
  assign readyN = qEmpty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= qWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    ladOut = '0;
    if (strobes.driveBus) begin
      if (isPrefetch) ladOut = qEmpty ? '0 : mem[rdPtr];
      else            ladOut = regRead;
    end
  end

  AST_READY_RISE_NEEDS_POP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyN) |-> $past(strobes.popQ)); // R2
  AST_POP_ONE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (doPop && !doPush) |=> (count == $past(count) - 1'b1)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && !doPop) |=> qFull); // R10
  AST_REG_WR_NOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regWr |-> !isPrefetch); // R8
endmodule

// File: rtl/lb_prefetch_slave.sv
module lb_prefetch_slave
  import lbps_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adsN,
  input  logic              wnR,
  input  logic              blastN,
  input  logic [DATA_W-1:0] ladIn,
  output logic [DATA_W-1:0] ladOut,
  output logic              ladOe,
  output logic              readyN,
  input  logic              qWrEn,
  input  logic [DATA_W-1:0] qWrData,
  output logic              qFull
);
  lbStrobes_t strobes;
  logic       isPrefetch;
  logic       qEmpty;

  lbps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .adsN(adsN), .wnR(wnR), .blastN(blastN),
    .isPrefetch(isPrefetch), .qEmpty(qEmpty), .strobes(strobes), .ladOe(ladOe)
  );

  lbps_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ladIn(ladIn),
    .qWrEn(qWrEn), .qWrData(qWrData), .ladOut(ladOut),
    .isPrefetch(isPrefetch), .qEmpty(qEmpty), .qFull(qFull), .readyN(readyN)
  );
endmodule

// File: tb/lb_prefetch_slave_bench.sv
`timescale 1ns/1ps
module lb_prefetch_slave_bench;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adsN = 1'b1, wnR = 1'b0, blastN = 1'b1, qWrEn = 1'b0;
  logic [DW-1:0] ladIn = '0, qWrData = '0, ladOut;
  logic ladOe, readyN, qFull;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] rdBuf [8];
  logic          oeBuf [8];
  logic [DW-1:0] wrBuf [8];

  always #2.5 clk = ~clk;

  lb_prefetch_slave #(.ADDR_W(16), .DATA_W(DW), .DEPTH(DEPTH), .NUM_REGS(4)) u_lb_prefetch_slave (
    .clk(clk), .rstN(rstN), .adsN(adsN), .wnR(wnR), .blastN(blastN),
    .ladIn(ladIn), .ladOut(ladOut), .ladOe(ladOe), .readyN(readyN),
    .qWrEn(qWrEn), .qWrData(qWrData), .qFull(qFull)
  );

  // {address, write data, expected readback}
  localparam logic [47:0] VEC [5] = '{
    {16'h0001, 16'hA5A5, 16'hA5A5},
    {16'h0002, 16'h1234, 16'h1234},
    {16'h0003, 16'hFFFF, 16'hFFFF},
    {16'h0004, 16'h0F0F, 16'h0F0F},
    {16'h0005, 16'hBEEF, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart(input logic [15:0] addr, input logic wr);
    @(negedge clk);
    adsN = 1'b0; wnR = wr; ladIn = addr;
    @(negedge clk);
    adsN = 1'b1; wnR = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] addr, input int n);
    busStart(addr, 1'b0);
    for (int i = 0; i < n; i++) begin
      blastN = (i == n - 1) ? 1'b0 : 1'b1;
      rdBuf[i] = ladOut;
      oeBuf[i] = ladOe;
      @(negedge clk);
    end
    blastN = 1'b1;
  endtask

  task automatic busWrite(input logic [15:0] addr, input int n);
    busStart(addr, 1'b1);
    for (int i = 0; i < n; i++) begin
      blastN = (i == n - 1) ? 1'b0 : 1'b1;
      ladIn = wrBuf[i];
      @(negedge clk);
    end
    blastN = 1'b1;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk);
    qWrEn = 1'b1; qWrData = d;
    @(negedge clk);
    qWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL R3 watchdog actual=hang expected=finish");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 readyN", readyN, 1);
    check("R1 ladOe", ladOe, 0);
    check("R1 qFull", qFull, 0);
    busRead(16'h0003, 1);
    check("R1 reg reset", rdBuf[0], 0);

    // table: single-beat write then read back
    for (int v = 0; v < 5; v++) begin
      wrBuf[0] = VEC[v][31:16];
      busWrite(VEC[v][47:32], 1);
      busRead(VEC[v][47:32], 1);
      check(v == 4 ? "R8 out of range" : "R7 readback", rdBuf[0], VEC[v][15:0]);
    end

    // R7/R3: burst write advances address
    wrBuf[0] = 16'h1111; wrBuf[1] = 16'h2222;
    busWrite(16'h0001, 2);
    busRead(16'h0001, 2);
    check("R7 burst beat0", rdBuf[0], 16'h1111);
    check("R7 burst beat1", rdBuf[1], 16'h2222);
    check("R3 oe in read", oeBuf[1], 1);
    check("R9 oe released", ladOe, 0);

    // streaming
    push(16'hC000); push(16'hC001); push(16'hC002);
    check("R2 readyN low", readyN, 0);
    busRead(16'h0000, 2);
    check("R4 head0", rdBuf[0], 16'hC000);
    check("R4 head1", rdBuf[1], 16'hC001);
    check("R9 oe during prefetch", oeBuf[0], 1);
    busRead(16'h0002, 1);
    check("R11 readyN held", readyN, 0);
    check("R11 reg read", rdBuf[0], 16'h2222);
    busRead(16'h0000, 1);
    check("R5 remaining word", rdBuf[0], 16'hC002);
    check("R2 readyN high", readyN, 1);

    // R6: empty prefetch
    busRead(16'h0000, 2);
    check("R6 empty data", rdBuf[0], 0);
    check("R6 readyN", readyN, 1);

    // R8: write to address 0 ignored
    push(16'hD00D);
    wrBuf[0] = 16'h7777;
    busWrite(16'h0000, 1);
    check("R8 addr0 write readyN", readyN, 0);
    busRead(16'h0000, 1);
    check("R8 addr0 write no effect", rdBuf[0], 16'hD00D);

    // R10: overflow
    for (int k = 0; k < DEPTH + 1; k++) push(16'hE000 + 16'(k));
    check("R10 qFull", qFull, 1);
    busRead(16'h0000, DEPTH);
    for (int k = 0; k < DEPTH; k++) check("R10 order", rdBuf[k], 16'hE000 + 16'(k));
    check("R10 extra dropped", readyN, 1);
    check("R10 qFull clear", qFull, 0);

    done = 1'b1;
    finishRun();
  end
endmodule